// File: doc/BRIEF.md
# Multiplexer Carry Chain Adder

This block is an unsigned adder of configurable width whose carry ripples from the least significant bit to the most significant bit. Each bit works in three steps. An XOR of the two operand bits gives a propagate term. A 2:1 multiplexer steered by that term picks the next carry. A second XOR forms the sum bit. The bits are grouped in pairs, as in a two-bit slice. If the width is odd, the top pair has only one bit in use.

A two-bit mode input sets up the same chain for four jobs:
- addition;
- subtraction, with operand B inverted and a forced carry-in;
- unsigned comparison, where the flag comes from the inverted carry-out;
- a free-running counter, which feeds its own register back into the chain.

An optional output register delays the sum, carry-out and less-than flag by one clock.

Top module: `mux_carry_adder`

## Requirements
- R1: For each bit, propagate = x XOR y. The carry to the next bit is the incoming carry when propagate is 1 and y when propagate is 0. The sum bit is propagate XOR the incoming carry.
- R2: With mode = 2'b00 (add), {cout, sum} equals a + b + cin.
- R3: With mode = 2'b01 (subtract), sum equals (a - b) mod 2^WIDTH. cout is 1 exactly when a >= b. a_lt_b is 1 exactly when a < b. cin has no effect.
- R4: With mode = 2'b10 (compare), a_lt_b is 1 exactly when a < b unsigned. cout is the inverse of a_lt_b. sum is all zeros. cin has no effect.
- R5: a_lt_b is 0 in add mode (2'b00) and in count mode (2'b11).
- R6: With mode = 2'b11 (count), the internal counter advances by 1 (mod 2^WIDTH) on each clock with cnt_en = 1 and holds its value with cnt_en = 0. sum shows the counter value before the update. cout is 1 exactly when that value is all ones and cnt_en = 1.
- R7: The counter resets to 0. It keeps its value across any time spent in modes other than count.
- R8: With REG_OUT = 1, sum, cout and a_lt_b are registered. They show the result of the inputs present at the previous rising edge, do not follow input changes between edges, and read 0 during reset. With REG_OUT = 0 they are combinational.
- R9: Results are correct for an odd WIDTH, where the top slice carries a single bit and cout is the carry out of bit WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 add, 01 subtract, 10 compare, 11 count |
| cnt_en | input | 1 | Count enable in count mode |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| cin | input | 1 | Carry-in, used in add mode only |
| sum | output | WIDTH | Sum, difference or counter value |
| cout | output | 1 | Carry out of the top bit |
| a_lt_b | output | 1 | Unsigned A less than B flag |

## Verification
The bench builds the block with WIDTH = 5 and REG_OUT = 1. An odd width leaves the top slice half used, which exercises R9. The 32-value operand range is small enough to sweep every pair of operands with both carry-in values in add, subtract and compare modes. The counter runs past its 31-to-0 wrap with a gapped enable, and the registered outputs make the one-cycle latency and the hold between edges observable.

// File: rtl/mux_carry_adder.sv
module mux_carry_adder #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             a_lt_b
);

  localparam int SLICES = (WIDTH + 1) / 2;
  localparam int W1 = WIDTH + 1;
  localparam logic [1:0] M_ADD = 2'b00;
  localparam logic [1:0] M_SUB = 2'b01;
  localparam logic [1:0] M_CMP = 2'b10;
  localparam logic [1:0] M_CNT = 2'b11;

  logic [WIDTH-1:0] cnt_q, x, y, p, s, s_c;
  logic [WIDTH:0]   cy;
  logic             c_c, lt_c;

  assign x     = (mode == M_CNT) ? cnt_q : a;
  assign y     = (mode == M_CNT) ? '0 : (mode == M_ADD) ? b : ~b;
  assign cy[0] = (mode == M_ADD) ? cin : (mode == M_CNT) ? cnt_en : 1'b1;

  for (genvar sl = 0; sl < SLICES; sl++) begin : g_slice
    for (genvar k = 0; k < 2; k++) begin : g_bit
      if (2 * sl + k < WIDTH) begin : g_used
        localparam int I = 2 * sl + k;
        assign p[I]    = x[I] ^ y[I];
        assign cy[I+1] = p[I] ? cy[I] : y[I];
        assign s[I]    = p[I] ^ cy[I];
      end
    end
  end

  assign s_c  = (mode == M_CMP) ? '0 : (mode == M_CNT) ? cnt_q : s;
  assign c_c  = cy[WIDTH];
  assign lt_c = ((mode == M_SUB) || (mode == M_CMP)) && !cy[WIDTH];

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (mode == M_CNT)  cnt_q <= s;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sum    <= '0;
        cout   <= 1'b0;
        a_lt_b <= 1'b0;
      end else begin
        sum    <= s_c;
        cout   <= c_c;
        a_lt_b <= lt_c;
      end
    end

    a_r8_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sum == $past(s_c)) && (cout == $past(c_c)) && (a_lt_b == $past(lt_c)));
  end else begin : g_comb
    assign sum    = s_c;
    assign cout   = c_c;
    assign a_lt_b = lt_c;
  end

  a_r2_add: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ADD) |-> ({c_c, s_c} == W1'(a) + W1'(b) + W1'(cin)));

  a_r3_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUB) |-> ((s_c == WIDTH'(a - b)) && (c_c == (a >= b))));

  a_r4_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CMP) |-> ((lt_c == (a < b)) && (c_c == !lt_c) && (s_c == '0)));

  a_r5_no_lt: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_ADD) || (mode == M_CNT)) |-> !lt_c);

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CNT) |=> (cnt_q == WIDTH'($past(cnt_q) + WIDTH'($past(cnt_en)))));

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_CNT) |=> $stable(cnt_q));

endmodule

// File: tb/sim_mux_carry_adder.sv
module sim_mux_carry_adder;
  localparam int W = 5;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         cnt_en = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout, a_lt_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_carry_adder #(.WIDTH(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_en(cnt_en),
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .a_lt_b(a_lt_b)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic en, input int av, input int bv, input logic ci);
    mode = m; cnt_en = en; a = W'(av); b = W'(bv); cin = ci;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int mcnt;
    int t;
    repeat (3) @(negedge clk);
    check("R8 reset sum", int'(sum), 0);
    check("R8 reset cout", int'(cout), 0);
    check("R8 reset lt", int'(a_lt_b), 0);
    rst_n = 1'b1;

    for (int ai = 0; ai < N; ai++)
      for (int bi = 0; bi < N; bi++)
        for (int ci = 0; ci < 2; ci++) begin
          apply(2'b00, 1'b0, ai, bi, ci[0]);
          t = ai + bi + ci;
          check("R2 R1 R9 add sum", int'(sum), t % N);
          check("R2 R9 add cout", int'(cout), t / N);
          check("R5 add lt", int'(a_lt_b), 0);
        end

    for (int ai = 0; ai < N; ai++)
      for (int bi = 0; bi < N; bi++)
        for (int ci = 0; ci < 2; ci++) begin
          apply(2'b01, 1'b0, ai, bi, ci[0]);
          check("R3 sub diff", int'(sum), (ai - bi + N) % N);
          check("R3 sub cout", int'(cout), (ai >= bi) ? 1 : 0);
          check("R3 sub lt", int'(a_lt_b), (ai < bi) ? 1 : 0);
        end

    for (int ai = 0; ai < N; ai++)
      for (int bi = 0; bi < N; bi++)
        for (int ci = 0; ci < 2; ci++) begin
          apply(2'b10, 1'b0, ai, bi, ci[0]);
          check("R4 cmp lt", int'(a_lt_b), (ai < bi) ? 1 : 0);
          check("R4 cmp cout", int'(cout), (ai >= bi) ? 1 : 0);
          check("R4 cmp sum zero", int'(sum), 0);
        end

    mcnt = 0;
    for (int i = 0; i < 90; i++) begin
      logic en;
      en = ((i % 7) != 3);
      apply(2'b11, en, (i * 5) % N, (i * 3) % N, i[0]);
      check("R6 count sum", int'(sum), mcnt);
      check("R6 count cout", int'(cout), (en && mcnt == N - 1) ? 1 : 0);
      check("R5 count lt", int'(a_lt_b), 0);
      mcnt = (mcnt + (en ? 1 : 0)) % N;
    end

    apply(2'b00, 1'b0, 9, 17, 1'b1);
    apply(2'b01, 1'b0, 3, 20, 1'b0);
    apply(2'b10, 1'b0, 31, 0, 1'b1);
    apply(2'b11, 1'b0, 0, 0, 1'b0);
    check("R7 counter kept across modes", int'(sum), mcnt);
    apply(2'b11, 1'b0, 0, 0, 1'b0);
    check("R6 disabled hold", int'(sum), mcnt);
    check("R6 disabled cout", int'(cout), 0);

    apply(2'b00, 1'b0, 3, 4, 1'b0);
    check("R8 latency sum", int'(sum), 7);
    a = W'(10); b = W'(11);
    #1;
    check("R8 hold between edges", int'(sum), 7);
    @(posedge clk);
    @(negedge clk);
    check("R8 next edge sum", int'(sum), 21);

    apply(2'b00, 1'b0, 31, 31, 1'b1);
    check("R9 top carry", int'(cout), 1);
    check("R9 top sum", int'(sum), 31);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule